// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

A synchronous state machine that sums coin credit toward a fixed twenty-cent item price. Each clock cycle it may take one coin strobe: a nickel (5 cents), a dime (10 cents) or a quarter (25 cents). Credit below the price is held in a small state register that counts in nickel units, so it can only be 0, 5, 10 or 15 cents.

When the coin in the current cycle brings the credit to twenty cents or more, the controller raises a vend strobe and presents the change owed. Both appear in that same cycle, since they are decoded from the present state and the coin input. At the next clock edge the credit returns to zero, ready for another purchase. The change is given as a count of nickels. The largest overshoot comes from a quarter added to fifteen cents, which returns twenty cents (four nickels).

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the credit to zero. With no coin applied after reset, vend_o is 0 and change_o is 0.
- R2: The coin values are nickel = 1 unit, dime = 2 units and quarter = 5 units, where one unit is 5 cents. A single valid strobe adds its value to the credit at the next rising edge when the sum stays below the price.
- R3: vend_o is 1 in exactly those cycles where one valid coin strobe is present and credit plus coin value is at least 4 units (20 cents). It is combinational from the state and the inputs.
- R4: In a vend cycle, change_o equals credit plus coin value minus 4, in nickel units (3 bits, 0 to 4).
- R5: After a vend cycle, the credit is zero at the next rising edge.
- R6: A cycle with no coin strobe leaves the credit unchanged and gives vend_o = 0 and change_o = 0.
- R7: A cycle with two or three coin strobes active is ignored. The credit is unchanged, vend_o is 0 and change_o is 0.
- R8: change_o is 0 in every cycle in which vend_o is 0.
- R9: A quarter inserted at 15 cents credit vends with change_o = 4 (20 cents).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | Nickel strobe for this cycle |
| dime_i | input | 1 | Dime strobe for this cycle |
| quarter_i | input | 1 | Quarter strobe for this cycle |
| vend_o | output | 1 | Vend strobe, valid in the completing coin's cycle |
| change_o | output | 3 | Change owed in nickels, valid with vend_o |

## Verification
The bench builds the controller with its default parameters: a four-unit price and coins worth one, two and five units. This keeps the state space at four credit values and eight strobe patterns, so a sweep can apply every pattern from every credit value. That sweep reaches each overshoot amount, including the four-nickel maximum, along with the idle and multi-strobe cases. A long pseudo-random strobe stream is then checked against an arithmetic model of credit and change.

// File: rtl/vend_pkg.sv
package vend_pkg;
    // Bit position of each coin within the strobe vector.
    localparam int NUM_COINS = 3;
    localparam int IDX_NICKEL = 0;
    localparam int IDX_DIME = 1;
    localparam int IDX_QUARTER = 2;
endpackage

// File: rtl/coin_decode.sv
module coin_decode
    import vend_pkg::*;
#(
    parameter int NICKEL_UNITS = 1,
    parameter int DIME_UNITS = 2,
    parameter int QUARTER_UNITS = 5,
    parameter int VAL_W = 3
) (
    input  logic [NUM_COINS-1:0] coin_i,
    output logic                 valid_o,
    output logic [VAL_W-1:0]     value_o
);
    logic [1:0] hits;

    always_comb begin
        hits = '0;
        for (int k = 0; k < NUM_COINS; k++) begin
            hits = hits + {1'b0, coin_i[k]};
        end
        valid_o = (hits == 2'd1);
        value_o = '0;
        if (valid_o) begin
            if (coin_i[IDX_NICKEL]) value_o = VAL_W'(NICKEL_UNITS);
            else if (coin_i[IDX_DIME]) value_o = VAL_W'(DIME_UNITS);
            else value_o = VAL_W'(QUARTER_UNITS);
        end
    end
endmodule

// File: rtl/credit_step.sv
module credit_step #(
    parameter int PRICE_UNITS = 4,
    parameter int CREDIT_W = 2,
    parameter int VAL_W = 3,
    parameter int SUM_W = 4,
    parameter int CHG_W = 3
) (
    input  logic [CREDIT_W-1:0] credit_i,
    input  logic                valid_i,
    input  logic [VAL_W-1:0]    value_i,
    output logic [CREDIT_W-1:0] credit_o,
    output logic                vend_o,
    output logic [CHG_W-1:0]    change_o
);
    logic [SUM_W-1:0] total;

    always_comb begin
        total = SUM_W'(credit_i) + SUM_W'(value_i);
        credit_o = credit_i;
        vend_o = 1'b0;
        change_o = '0;
        if (valid_i) begin
            if (total >= SUM_W'(PRICE_UNITS)) begin
                vend_o = 1'b1;
                change_o = CHG_W'(total - SUM_W'(PRICE_UNITS));
                credit_o = '0;
            end else begin
                credit_o = CREDIT_W'(total);
            end
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int PRICE_UNITS = 4,
    parameter int NICKEL_UNITS = 1,
    parameter int DIME_UNITS = 2,
    parameter int QUARTER_UNITS = 5,
    localparam int MAX_COIN = (QUARTER_UNITS > DIME_UNITS)
        ? ((QUARTER_UNITS > NICKEL_UNITS) ? QUARTER_UNITS : NICKEL_UNITS)
        : ((DIME_UNITS > NICKEL_UNITS) ? DIME_UNITS : NICKEL_UNITS),
    localparam int CHG_W = (MAX_COIN > 2) ? $clog2(MAX_COIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nickel_i,
    input  logic             dime_i,
    input  logic             quarter_i,
    output logic             vend_o,
    output logic [CHG_W-1:0] change_o
);
    localparam int CREDIT_W = (PRICE_UNITS > 2) ? $clog2(PRICE_UNITS) : 1;
    localparam int VAL_W = $clog2(MAX_COIN + 1);
    localparam int SUM_W = $clog2(PRICE_UNITS + MAX_COIN);
    localparam int MAX_CHANGE = MAX_COIN - 1;

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
    } state_t;

    state_t state_d, state_q;
    logic [NUM_COINS-1:0] coins;
    logic coin_ok;
    logic [VAL_W-1:0] coin_val;
    logic [CREDIT_W-1:0] credit_nx;

    always_comb begin
        coins = '0;
        coins[IDX_NICKEL] = nickel_i;
        coins[IDX_DIME] = dime_i;
        coins[IDX_QUARTER] = quarter_i;
    end

    coin_decode #(
        .NICKEL_UNITS(NICKEL_UNITS), .DIME_UNITS(DIME_UNITS),
        .QUARTER_UNITS(QUARTER_UNITS), .VAL_W(VAL_W)
    ) u_decode (
        .coin_i(coins), .valid_o(coin_ok), .value_o(coin_val)
    );

    credit_step #(
        .PRICE_UNITS(PRICE_UNITS), .CREDIT_W(CREDIT_W), .VAL_W(VAL_W),
        .SUM_W(SUM_W), .CHG_W(CHG_W)
    ) u_step (
        .credit_i(state_q.credit), .valid_i(coin_ok), .value_i(coin_val),
        .credit_o(credit_nx), .vend_o(vend_o), .change_o(change_o)
    );

    always_comb begin
        state_d = state_q;
        state_d.credit = credit_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else state_q <= state_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> state_q.credit == '0);
    // R5
    vend_zero_chk: assert property (@(posedge clk) disable iff (rst)
        vend_o |=> state_q.credit == '0);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i && !quarter_i) |=> $stable(state_q.credit));
    // R7
    multi_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({nickel_i, dime_i, quarter_i}) > 1) |-> !vend_o);
    // R7
    multi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({nickel_i, dime_i, quarter_i}) > 1) |=> $stable(state_q.credit));
    // R8
    quiet_change_chk: assert property (@(posedge clk) disable iff (rst)
        !vend_o |-> change_o == '0);
    // R4
    change_range_chk: assert property (@(posedge clk) disable iff (rst)
        vend_o |-> change_o <= CHG_W'(MAX_CHANGE));
    // R3
    vend_needs_coin_chk: assert property (@(posedge clk) disable iff (rst)
        vend_o |-> $countones({nickel_i, dime_i, quarter_i}) == 1);
endmodule

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0, dime = 1'b0, quarter = 1'b0;
    logic vend;
    logic [2:0] change;
    int checks = 0;
    int errors = 0;
    int ref_credit = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vend_ctrl u_vend_ctrl (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
        .quarter_i(quarter), .vend_o(vend), .change_o(change)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle's strobes after a falling edge, check outputs, then clock.
    task automatic step(input logic n, input logic d, input logic q);
        int cnt, val, sum, exp_vend, exp_chg;
        string tag;
        @(negedge clk);
        nickel = n; dime = d; quarter = q;
        #1;
        cnt = int'(n) + int'(d) + int'(q);
        val = n ? 1 : (d ? 2 : 5);
        sum = ref_credit + val;
        exp_vend = 0; exp_chg = 0;
        if (cnt == 0) tag = "R6 idle";
        else if (cnt > 1) tag = "R7 multi";
        else if (sum >= 4) begin
            exp_vend = 1; exp_chg = sum - 4;
            tag = (ref_credit == 3 && q) ? "R9 quarter at 15" : "R3 vend";
        end else tag = "R2 accumulate";
        check(tag, int'(vend), exp_vend);
        check(exp_vend ? "R4 change" : "R8 change idle", int'(change), exp_chg);
        if (cnt == 1) ref_credit = exp_vend ? 0 : sum;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset vend", int'(vend), 0);
        check("R1 reset change", int'(change), 0);
        // R1: credit zero after reset shows as quarter giving one nickel change
        step(1'b0, 1'b0, 1'b1);
        check("R5 credit cleared after vend", ref_credit, 0);
        // Sweep every strobe pattern from every credit value.
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 8; p++) begin
                while (ref_credit != 0) step(1'b1, 1'b0, 1'b0);
                for (int k = 0; k < c; k++) step(1'b1, 1'b0, 1'b0);
                step(p[0], p[1], p[2]);
                // follow-up nickel exposes the held or cleared credit
                step(1'b1, 1'b0, 1'b0);
            end
        end
        // Mid-reset while credit is nonzero.
        step(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        nickel = 0; dime = 0; quarter = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_credit = 0;
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        // Pseudo-random stream, mostly single coins.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            if (r < 4) step(1'b1, 1'b0, 1'b0);
            else if (r < 8) step(1'b0, 1'b1, 1'b0);
            else if (r < 11) step(1'b0, 1'b0, 1'b1);
            else if (r < 13) step(1'b0, 1'b0, 1'b0);
            else step(r[0], 1'b1, r[1] | ~r[0]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule